// File: doc/BRIEF.md
# Exception and Interrupt Sequencer

This block sits beside the execute stage of a 32-bit processor and decides, each time execute finishes an instruction, whether control must leave the normal flow. It looks at a pending exception code from execute, an undefined-instruction flag and five maskable interrupt request lines. It weighs them against the current program status word (PSW). When something is taken it captures the current PC and PSW, then produces the vector to jump to, the values to load into the save registers, the cause code and the modified PSW.

There are three save paths. An ordinary exception loads the exception save registers and the ordinary cause field. An exception raised while the exception-pending flag is already set (duplexed) loads the second save pair and the fatal cause field, and always jumps to one fixed vector. When the NMI-pending flag is set the case is fatal. The block first dumps a three-word record to memory over a valid/ready write port, and only then commits the register updates on the duplexed or ordinary path, whichever applies. All register updates are delivered as one-cycle load strobes. The register file that holds the state lives outside this block.

Top module: `excSeqTop`

## Requirements
- R1: After reset `busy`, `memWrValid`, `pcLoad`, `saveOrdLd` and `saveDupLd` are all low.
- R2: An interrupt is taken only if no exception or undefined instruction is reported in the same evaluation and PSW bits ID (bit 12), EP (bit 14) and NP (bit 15) are all zero. A masked interrupt with no exception has no effect: no strobe, no write, `busy` stays low.
- R3: Among active request lines the highest-numbered one wins, and the cause code is 0xFE00 | (line << 4).
- R4: A nonzero `excCode` is taken in preference to interrupts and to `undefInst`, and its value becomes the cause code.
- R5: `undefInst` with `excCode` zero raises cause code 0xFF90.
- R6: With EP clear, the commit raises `saveOrdLd` and the vector is 0xFFFF0000 | (code & 0xFFF0), except that a result of 0xFFFFFF70 becomes 0xFFFFFF60.
- R7: With EP set, the commit raises `saveDupLd` and the vector is 0xFFFFFFD0.
- R8: With NP set, three words are written before the commit: 0xFFFF0000 | code to address 0, then the captured PSW to address 4, then the captured PC to address 8. The commit strobes rise in the cycle after the third word is accepted.
- R9: While `memWrValid` is high and `memWrReady` is low, the address and data hold.
- R10: The committed PSW equals the captured PSW with AE (bit 13) cleared and ID (bit 12) set. When the code's upper byte is 0xFE, the level field (bits 19:16) is also set to code bits 7:4.
- R11: Without NP, the commit strobes are high for exactly the one cycle after the clock edge that samples `evalStb`. `evalStb` is ignored while `busy` is high. `savePc`, `savePsw` and `causeCode` carry the PC, PSW and code captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evalStb | input | 1 | Execute has finished an instruction; evaluate this cycle |
| excCode | input | 16 | Pending exception code from execute, zero for none |
| undefInst | input | 1 | Execute met an undefined opcode |
| irqLines | input | 5 | Maskable interrupt request lines |
| curPc | input | 32 | PC to save |
| curPsw | input | 32 | Current PSW |
| busy | output | 1 | Sequencer is dumping or committing |
| memWrValid | output | 1 | Dump write request valid |
| memWrReady | input | 1 | Memory accepts the dump write |
| memWrAddr | output | 32 | Dump write address |
| memWrData | output | 32 | Dump write data |
| pcLoad | output | 1 | Load `pcNext` into the PC and `pswNext` into the PSW |
| pcNext | output | 32 | Handler vector |
| pswNext | output | 32 | PSW to install |
| saveOrdLd | output | 1 | Load ordinary save registers and ordinary cause field |
| saveDupLd | output | 1 | Load duplexed save registers and fatal cause field |
| savePc | output | 32 | PC to store in the selected save register |
| savePsw | output | 32 | PSW to store in the selected save register |
| causeCode | output | 16 | Code for the selected cause field |

## Verification
A wrong priority or masking decision shows in the very cycle after `evalStb`, as a wrong `causeCode` or as a strobe that should or should not be there. A wrong captured EP or NP flag moves the whole sequence onto another path: dump writes appear or go missing, or the wrong save strobe fires. A dump counter that slips shows as a wrong address or word at the next accepted write, or as a commit one write too early or late. The bench stalls the write port at random and changes the inputs after capture, so state that leaks or is captured late shows up as wrong saved values.

// File: rtl/excSeqPkg.sv
`timescale 1ns/1ps
package excSeqPkg;
  // PSW field positions decoded by the surrounding core
  localparam int BIT_ID  = 12;
  localparam int BIT_AE  = 13;
  localparam int BIT_EP  = 14;
  localparam int BIT_NP  = 15;
  localparam int LVL_LSB = 16;
  localparam int LVL_W   = 4;

  localparam int CODE_W  = 16;
  localparam int WORD_W  = 32;
  localparam int DUMP_WORDS = 3;

  localparam logic [CODE_W-1:0] CODE_UNDEF = 16'hFF90;
  localparam logic [7:0]        IRQ_TAG    = 8'hFE;

  localparam logic [WORD_W-1:0] VEC_DUP       = 32'hFFFFFFD0;
  localparam logic [WORD_W-1:0] VEC_BASE      = 32'hFFFF0000;
  localparam logic [WORD_W-1:0] VEC_ALIAS     = 32'hFFFFFF70;
  localparam logic [WORD_W-1:0] VEC_ALIAS_TGT = 32'hFFFFFF60;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DUMP   = 2'd1,
    ST_COMMIT = 2'd2
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // latch code, PC, PSW
    logic dumpOn;    // a dump word is being offered
    logic dumpStep;  // the offered word is accepted
    logic commit;    // register updates go out this cycle
  } seqStrobe_t;
endpackage

// File: rtl/excPrio.sv
`timescale 1ns/1ps
module excPrio #(
  parameter int NUM_IRQ = 5
) (
  input  logic [NUM_IRQ-1:0]           irqLines,
  output logic                         anyReq,
  output logic [excSeqPkg::CODE_W-1:0] irqCode
);
  import excSeqPkg::*;

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] winMask;
  logic [IDX_W-1:0]   winIdx;

  // a line wins when no higher-numbered line is active
  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_win
      if (g == NUM_IRQ - 1) begin : g_top
        assign winMask[g] = irqLines[g];
      end else begin : g_low
        assign winMask[g] = irqLines[g] & ~(|irqLines[NUM_IRQ-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (winMask[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyReq  = |irqLines;
  assign irqCode = {IRQ_TAG, LVL_W'(winIdx), 4'h0};
endmodule

// File: rtl/excCtrl.sv
`timescale 1ns/1ps
module excCtrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evalStb,
  input  logic                  takeReq,
  input  logic                  npNow,
  input  logic                  memWrReady,
  input  logic                  dumpLast,
  output excSeqPkg::seqStrobe_t strb,
  output logic                  busy
);
  import excSeqPkg::*;

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (evalStb && takeReq) begin
          strb.capture = 1'b1;
          stateNext    = npNow ? ST_DUMP : ST_COMMIT;
        end
      end
      ST_DUMP: begin
        strb.dumpOn = 1'b1;
        if (memWrReady) begin
          strb.dumpStep = 1'b1;
          if (dumpLast) stateNext = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        strb.commit = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/excDatapath.sv
`timescale 1ns/1ps
module excDatapath #(
  parameter int NUM_IRQ = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  excSeqPkg::seqStrobe_t        strb,
  input  logic [NUM_IRQ-1:0]           irqLines,
  input  logic [excSeqPkg::CODE_W-1:0] excCode,
  input  logic                         undefInst,
  input  logic [excSeqPkg::WORD_W-1:0] curPc,
  input  logic [excSeqPkg::WORD_W-1:0] curPsw,
  output logic                         takeReq,
  output logic                         npNow,
  output logic                         dumpLast,
  output logic [excSeqPkg::WORD_W-1:0] memWrAddr,
  output logic [excSeqPkg::WORD_W-1:0] memWrData,
  output logic [excSeqPkg::WORD_W-1:0] pcNext,
  output logic [excSeqPkg::WORD_W-1:0] pswNext,
  output logic [excSeqPkg::WORD_W-1:0] savePc,
  output logic [excSeqPkg::WORD_W-1:0] savePsw,
  output logic [excSeqPkg::CODE_W-1:0] causeCode,
  output logic                         dupPath
);
  import excSeqPkg::*;

  localparam int IDX_W = $clog2(DUMP_WORDS);

  logic              irqAny;
  logic [CODE_W-1:0] irqCode;
  logic              irqOk;
  logic [CODE_W-1:0] codeNow;

  logic [CODE_W-1:0] codeQ;
  logic [WORD_W-1:0] pcQ, pswQ;
  logic [IDX_W-1:0]  dumpIdx;

  logic [WORD_W-1:0] ordVec;

  excPrio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .irqLines(irqLines),
    .anyReq  (irqAny),
    .irqCode (irqCode)
  );

  // exceptions first, then undefined opcode, then a maskable request
  always_comb begin
    irqOk = irqAny && (excCode == '0) && !undefInst &&
            !curPsw[BIT_ID] && !curPsw[BIT_EP] && !curPsw[BIT_NP];
    if (excCode != '0)   codeNow = excCode;
    else if (undefInst)  codeNow = CODE_UNDEF;
    else if (irqOk)      codeNow = irqCode;
    else                 codeNow = '0;
  end

  assign takeReq = (codeNow != '0);
  assign npNow   = curPsw[BIT_NP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      pcQ   <= '0;
      pswQ  <= '0;
    end else if (strb.capture) begin
      codeQ <= codeNow;
      pcQ   <= curPc;
      pswQ  <= curPsw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dumpIdx <= '0;
    else if (strb.capture)  dumpIdx <= '0;
    else if (strb.dumpStep) dumpIdx <= dumpIdx + 1'b1;
  end

  assign dumpLast  = (dumpIdx == IDX_W'(DUMP_WORDS - 1));
  assign memWrAddr = {{(WORD_W-IDX_W-2){1'b0}}, dumpIdx, 2'b00};

  always_comb begin
    unique case (dumpIdx)
      IDX_W'(0): memWrData = VEC_BASE | {{(WORD_W-CODE_W){1'b0}}, codeQ};
      IDX_W'(1): memWrData = pswQ;
      default:   memWrData = pcQ;
    endcase
  end

  // vector selection and PSW update
  always_comb begin
    ordVec = VEC_BASE | {{(WORD_W-CODE_W){1'b0}}, codeQ & 16'hFFF0};
    if (ordVec == VEC_ALIAS) ordVec = VEC_ALIAS_TGT;
  end

  assign dupPath = pswQ[BIT_EP];
  assign pcNext  = dupPath ? VEC_DUP : ordVec;

  always_comb begin
    pswNext         = pswQ;
    pswNext[BIT_AE] = 1'b0;
    pswNext[BIT_ID] = 1'b1;
    if (codeQ[CODE_W-1:CODE_W-8] == IRQ_TAG)
      pswNext[LVL_LSB +: LVL_W] = codeQ[7:4];
  end

  assign savePc    = pcQ;
  assign savePsw   = pswQ;
  assign causeCode = codeQ;
endmodule

// File: rtl/excSeqTop.sv
`timescale 1ns/1ps
module excSeqTop #(
  parameter int NUM_IRQ = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evalStb,
  input  logic [15:0]        excCode,
  input  logic               undefInst,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic [31:0]        curPc,
  input  logic [31:0]        curPsw,
  output logic               busy,
  output logic               memWrValid,
  input  logic               memWrReady,
  output logic [31:0]        memWrAddr,
  output logic [31:0]        memWrData,
  output logic               pcLoad,
  output logic [31:0]        pcNext,
  output logic [31:0]        pswNext,
  output logic               saveOrdLd,
  output logic               saveDupLd,
  output logic [31:0]        savePc,
  output logic [31:0]        savePsw,
  output logic [15:0]        causeCode
);
  import excSeqPkg::*;

  seqStrobe_t strb;
  logic takeReq, npNow, dumpLast, dupPath;

  excCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evalStb   (evalStb),
    .takeReq   (takeReq),
    .npNow     (npNow),
    .memWrReady(memWrReady),
    .dumpLast  (dumpLast),
    .strb      (strb),
    .busy      (busy)
  );

  excDatapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .irqLines (irqLines),
    .excCode  (excCode),
    .undefInst(undefInst),
    .curPc    (curPc),
    .curPsw   (curPsw),
    .takeReq  (takeReq),
    .npNow    (npNow),
    .dumpLast (dumpLast),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData),
    .pcNext   (pcNext),
    .pswNext  (pswNext),
    .savePc   (savePc),
    .savePsw  (savePsw),
    .causeCode(causeCode),
    .dupPath  (dupPath)
  );

  assign memWrValid = strb.dumpOn;
  assign pcLoad     = strb.commit;
  assign saveOrdLd  = strb.commit & ~dupPath;
  assign saveDupLd  = strb.commit &  dupPath;
endmodule

// File: rtl/excSeqChk.sv
`timescale 1ns/1ps
module excSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        evalStb,
  input logic [15:0] excCode,
  input logic        busy,
  input logic        memWrValid,
  input logic        memWrReady,
  input logic [31:0] memWrAddr,
  input logic [31:0] memWrData,
  input logic        pcLoad,
  input logic [31:0] pcNext,
  input logic [31:0] pswNext,
  input logic        saveOrdLd,
  input logic        saveDupLd
);
  // R9
  dump_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && !memWrReady |=> memWrValid && $stable(memWrAddr) && $stable(memWrData));

  // R8
  dump_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> (memWrAddr == 32'd0 || memWrAddr == 32'd4 || memWrAddr == 32'd8));

  // R8
  dump_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && memWrReady && memWrAddr != 32'd8 |=> memWrValid && memWrAddr == $past(memWrAddr) + 32'd4);

  // R8
  dump_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && memWrReady && memWrAddr == 32'd8 |=> pcLoad && !memWrValid);

  // R6 R7
  one_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> $countones({saveOrdLd, saveDupLd}) == 1);

  // R6 R7
  no_stray_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pcLoad |-> !saveOrdLd && !saveDupLd);

  // R7
  dup_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveDupLd |-> pcNext == 32'hFFFFFFD0);

  // R6
  ord_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveOrdLd |-> pcNext[31:16] == 16'hFFFF && pcNext[3:0] == 4'h0 && pcNext != 32'hFFFFFF70);

  // R10
  psw_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> !pswNext[13] && pswNext[12]);

  // R11
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad && !busy);

  // R11
  exc_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && evalStb && excCode != 16'h0 |=> busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWrValid && !pcLoad);
endmodule

bind excSeqTop excSeqChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evalStb   (evalStb),
  .excCode   (excCode),
  .busy      (busy),
  .memWrValid(memWrValid),
  .memWrReady(memWrReady),
  .memWrAddr (memWrAddr),
  .memWrData (memWrData),
  .pcLoad    (pcLoad),
  .pcNext    (pcNext),
  .pswNext   (pswNext),
  .saveOrdLd (saveOrdLd),
  .saveDupLd (saveDupLd)
);

// File: tb/sim_excSeqTop.sv
`timescale 1ns/1ps
module sim_excSeqTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalStb = 1'b0;
  logic [15:0] excCode = '0;
  logic        undefInst = 1'b0;
  logic [4:0]  irqLines = '0;
  logic [31:0] curPc = '0;
  logic [31:0] curPsw = '0;
  logic        memWrReady = 1'b0;
  logic        busy, memWrValid, pcLoad, saveOrdLd, saveDupLd;
  logic [31:0] memWrAddr, memWrData, pcNext, pswNext, savePc, savePsw;
  logic [15:0] causeCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  excSeqTop u0 (
    .clk(clk), .rstN(rstN), .evalStb(evalStb), .excCode(excCode),
    .undefInst(undefInst), .irqLines(irqLines), .curPc(curPc), .curPsw(curPsw),
    .busy(busy), .memWrValid(memWrValid), .memWrReady(memWrReady),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .pcLoad(pcLoad),
    .pcNext(pcNext), .pswNext(pswNext), .saveOrdLd(saveOrdLd),
    .saveDupLd(saveDupLd), .savePc(savePc), .savePsw(savePsw),
    .causeCode(causeCode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // ---- reference model from the requirements ----
  function automatic logic [15:0] refCode(input logic [4:0] irq, input logic [15:0] exc,
                                          input logic und, input logic [31:0] psw);
    logic [3:0] lvl = 4'd0;
    if (exc != 16'h0) return exc;                 // R4
    if (und) return 16'hFF90;                     // R5
    if (irq == 5'd0 || psw[12] || psw[14] || psw[15]) return 16'h0;  // R2
    for (int i = 0; i < 5; i++) if (irq[i]) lvl = 4'(i);             // R3
    return {8'hFE, lvl, 4'h0};
  endfunction

  function automatic logic [31:0] refVec(input logic [15:0] code, input logic [31:0] psw);
    logic [31:0] v;
    if (psw[14]) return 32'hFFFFFFD0;             // R7
    v = 32'hFFFF0000 | {16'h0, code & 16'hFFF0};  // R6
    if (v == 32'hFFFFFF70) v = 32'hFFFFFF60;
    return v;
  endfunction

  function automatic logic [31:0] refPsw(input logic [15:0] code, input logic [31:0] psw);
    logic [31:0] p = psw;                         // R10
    p[13] = 1'b0;
    p[12] = 1'b1;
    if (code[15:8] == 8'hFE) p[19:16] = code[7:4];
    return p;
  endfunction

  task automatic runCase(input logic [4:0] irq, input logic [15:0] exc, input logic und,
                         input logic [31:0] pc, input logic [31:0] psw,
                         input int stallMax, input bit poke);
    logic [15:0] code;
    logic [31:0] word;
    int stalls;
    code = refCode(irq, exc, und, psw);
    @(negedge clk);
    irqLines = irq; excCode = exc; undefInst = und; curPc = pc; curPsw = psw;
    evalStb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    evalStb = 1'b0;
    // scramble inputs to show the values were captured at the edge (R11)
    irqLines = 5'($urandom); excCode = 16'($urandom); undefInst = 1'($urandom);
    curPc = $urandom; curPsw = $urandom;
    if (code == 16'h0) begin
      chk("R2 no action busy", 32'(busy), 32'd0);
      chk("R2 no action pcLoad", 32'(pcLoad), 32'd0);
      chk("R2 no action write", 32'(memWrValid), 32'd0);
      return;
    end
    if (psw[15]) begin
      for (int w = 0; w < 3; w++) begin
        word = (w == 0) ? (32'hFFFF0000 | {16'h0, code}) : (w == 1) ? psw : pc;
        stalls = (stallMax == 0) ? 0 : int'($urandom % (stallMax + 1));
        for (int s = 0; s < stalls; s++) begin
          chk("R9 held valid", 32'(memWrValid), 32'd1);
          chk("R9 held addr", memWrAddr, 32'(w * 4));
          chk("R9 held data", memWrData, word);
          chk("R8 no early commit", 32'(pcLoad), 32'd0);
          if (poke) begin evalStb = 1'b1; excCode = 16'h0ABC; end
          @(posedge clk);
          @(negedge clk);
          evalStb = 1'b0;
        end
        chk("R8 dump valid", 32'(memWrValid), 32'd1);
        chk("R8 dump addr", memWrAddr, 32'(w * 4));
        chk("R8 dump data", memWrData, word);
        memWrReady = 1'b1;
        @(posedge clk);
        @(negedge clk);
        memWrReady = 1'b0;
      end
    end
    chk("R11 commit strobe", 32'(pcLoad), 32'd1);
    chk("R8 no write at commit", 32'(memWrValid), 32'd0);
    chk("R6 ordinary save", 32'(saveOrdLd), 32'(!psw[14]));
    chk("R7 duplexed save", 32'(saveDupLd), 32'(psw[14]));
    chk("R6 R7 vector", pcNext, refVec(code, psw));
    chk("R10 new psw", pswNext, refPsw(code, psw));
    chk("R11 saved pc", savePc, pc);
    chk("R11 saved psw", savePsw, psw);
    chk("R4 cause code", 32'(causeCode), 32'(code));
    @(posedge clk);
    @(negedge clk);
    chk("R11 one-cycle commit", 32'(pcLoad), 32'd0);
    chk("R11 back idle", 32'(busy), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset valid", 32'(memWrValid), 32'd0);
    chk("R1 reset pcLoad", 32'(pcLoad), 32'd0);
    chk("R1 reset saves", 32'({saveOrdLd, saveDupLd}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 priority, R10 level update
    runCase(5'b10110, 16'h0, 1'b0, 32'h00001000, 32'h000F0000, 0, 0);
    runCase(5'b00001, 16'h0, 1'b0, 32'h00002002, 32'h00002000, 0, 0);
    runCase(5'b00110, 16'h0, 1'b0, 32'h00002004, 32'h00000000, 0, 0);
    // R2 masking by ID, EP, NP
    runCase(5'b11111, 16'h0, 1'b0, 32'h10, 32'h00001000, 0, 0);
    runCase(5'b11111, 16'h0, 1'b0, 32'h10, 32'h00004000, 0, 0);
    runCase(5'b11111, 16'h0, 1'b0, 32'h10, 32'h00008000, 4, 0);
    runCase(5'b00000, 16'h0, 1'b0, 32'h10, 32'h00000000, 0, 0);
    // R4 exception beats interrupt and undefined opcode
    runCase(5'b10000, 16'h0400, 1'b1, 32'h00003000, 32'h00000000, 0, 0);
    // R5 undefined opcode
    runCase(5'b10000, 16'h0, 1'b1, 32'h00003004, 32'h00000000, 0, 0);
    // R6 vector remap
    runCase(5'b0, 16'hFF70, 1'b0, 32'h00004000, 32'h00002000, 0, 0);
    runCase(5'b0, 16'hFF7A, 1'b0, 32'h00004002, 32'h00000000, 0, 0);
    runCase(5'b0, 16'hFF64, 1'b0, 32'h00004004, 32'h00000000, 0, 0);
    // R7 duplexed
    runCase(5'b0, 16'hFF70, 1'b0, 32'h00005000, 32'h00006000, 0, 0);
    // R10 interrupt-shaped code from execute
    runCase(5'b0, 16'hFE30, 1'b0, 32'h00005004, 32'h00F02000, 0, 0);
    // R8 R9 fatal dump, with ignored evalStb pokes while busy (R11)
    runCase(5'b0, 16'h1234, 1'b0, 32'hABCD0000, 32'h00008000, 3, 1);
    runCase(5'b0, 16'hFF90, 1'b0, 32'hABCD0004, 32'h0000C000, 3, 1);
    runCase(5'b0, 16'h0010, 1'b0, 32'hABCD0008, 32'h0000A000, 0, 0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] psw;
      logic [15:0] exc;
      psw = $urandom & 32'h000FF3FF;
      if ($urandom % 3 == 0) psw[15] = 1'b0;
      if ($urandom % 2 == 0) psw[14] = 1'b0;
      if ($urandom % 2 == 0) psw[12] = 1'b0;
      exc = ($urandom % 2 == 0) ? 16'h0 : 16'($urandom);
      runCase(5'($urandom), exc, ($urandom % 8 == 0), $urandom & 32'hFFFFFFFE, psw,
              3, ($urandom % 2 == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule